// File: doc/BRIEF.md
# Three-Master Bus Arbiter

This block decides who owns a shared parallel bus that a host processor and three external masters compete for. Each external master raises an active-low request and receives an active-low grant. The host has a single active-high grant and takes part in no request handshake. It is the default owner: the bus is parked on it whenever no external master is waiting. A tenure lasts until the bus-idle input reports that the current owner has finished. Only then can ownership move, and it always passes through at least one cycle in which nobody holds a grant.

An 8-bit control register selects the arbitration policy. A 3-bit order code picks one of six permutations of the three masters. A 3-bit rotation mask says which masters drop to the bottom of the order after being served: no bits set gives fixed priority, all bits set gives a full round robin, and anything in between is a hybrid. A single alternation bit gives the host every second tenure, so ownership goes host, external master, host, external master, and so on. The control register is written and read over plain pins. The block has no data path, so it has no valid/ready stream interface. Requests need no back-pressure rule: a request is simply held until its grant arrives.

Top module: `tri_master_bus_arbiter`

## Requirements
- R1: After reset the control register reads 00h, the host grant is asserted, and all three external grants are high (inactive).
- R2: Register bit layout: bit 7 is the alternation enable, bits 6:4 are the order code, bits 2:0 are the rotation mask (bit i belongs to master i), and bit 3 always reads 0 whatever is written.
- R3: A write of order code 011 or 101 stores and reads back as order code 000.
- R4: With rotation mask 000, the waiting master earliest in the order code's list wins, highest first: 000 gives 0,1,2; 001 gives 1,0,2; 010 gives 0,2,1; 100 gives 1,2,0; 110 gives 2,1,0; 111 gives 2,0,1.
- R5: With rotation mask 111, a master that is granted moves to the lowest position and the others move up one place, so masters that keep requesting are served round robin.
- R6: With a partial rotation mask, only a granted master whose mask bit is 1 moves to the lowest position. A granted master whose bit is 0 keeps its position and wins again while it keeps requesting.
- R7: With the alternation bit set, every external tenure is followed by a host tenure even while external requests are pending, and the next arbitration after that host tenure serves external requests again.
- R8: At most one grant (the host grant or one of the three external grants) is active in any cycle.
- R9: While the bus-idle input is low, the active grant holds, whatever the requests do.
- R10: When ownership moves, at least one cycle with no grant active separates the old grant from the new one. With the default gap setting the new grant appears two clock edges after bus-idle is first sampled high.
- R11: While the host owns the bus and no external master may be served, the host grant stays asserted with no gap, even while bus-idle is high.
- R12: The rotation order is reloaded from the order code's list one cycle after every register write, and it otherwise changes only when a grant is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Writes cfg_wr_data into the control register at the clock edge |
| cfg_wr_data | input | 8 | Control register write value |
| cfg_rd_data | output | 8 | Current control register value |
| req_n | input | 3 | Active-low bus requests from external masters 0 to 2 |
| bus_idle | input | 1 | High when the current tenure has finished and the bus is free |
| gnt_n | output | 3 | Active-low grants to external masters 0 to 2 |
| host_gnt | output | 1 | Active-high grant to the host processor |

## Verification
The assertions check on every cycle the properties that do not depend on history longer than one step. There is never more than one grant. Grants hold while the bus is busy. A new grant is always preceded by a cycle with no grant. The host keeps a parked bus. An alternation tenure always hands over to the host. Reserved order codes fold to 000. A fixed-priority order never moves. Only the bench scenarios can show the serving sequences, because they unfold over several tenures: the six permutation orders, the round-robin and hybrid rotations, the host/external alternation under constant requests, and the reload of the order after a register write.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int N_MST = 3;
  localparam int IDX_W = 2;

  typedef logic [IDX_W-1:0] mst_idx_t;
  localparam mst_idx_t HOST_ID = 2'd3;

  // position 0 is the highest priority
  typedef logic [N_MST-1:0][IDX_W-1:0] order_t;

  typedef enum logic {PH_TENURE, PH_GAP} phase_e;

  typedef struct packed {
    logic       pp_en;
    logic [2:0] fix_code;
    logic [2:0] rot_en;
  } cfg_t;

  function automatic logic fix_code_legal(input logic [2:0] code);
    return !(code == 3'b011 || code == 3'b101);
  endfunction

  function automatic order_t fixed_order(input logic [2:0] code);
    order_t o;
    case (code)
      3'b001:  begin o[0] = 2'd1; o[1] = 2'd0; o[2] = 2'd2; end
      3'b010:  begin o[0] = 2'd0; o[1] = 2'd2; o[2] = 2'd1; end
      3'b100:  begin o[0] = 2'd1; o[1] = 2'd2; o[2] = 2'd0; end
      3'b110:  begin o[0] = 2'd2; o[1] = 2'd1; o[2] = 2'd0; end
      3'b111:  begin o[0] = 2'd2; o[1] = 2'd0; o[2] = 2'd1; end
      default: begin o[0] = 2'd0; o[1] = 2'd1; o[2] = 2'd2; end
    endcase
    return o;
  endfunction
endpackage

// File: rtl/arb_cfg_reg.sv
module arb_cfg_reg
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output cfg_t       cfg,
  output logic       reload
);
  cfg_t q;
  logic reload_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q        <= '0;
      reload_q <= 1'b0;
    end else begin
      reload_q <= wr_en;
      if (wr_en) begin
        q.pp_en    <= wr_data[7];
        q.fix_code <= fix_code_legal(wr_data[6:4]) ? wr_data[6:4] : 3'b000;
        q.rot_en   <= wr_data[2:0];
      end
    end
  end

  assign rd_data = {q.pp_en, q.fix_code, 1'b0, q.rot_en};
  assign cfg     = q;
  assign reload  = reload_q;

  // R3: reserved order codes fold to 000
  p_rsvd_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !fix_code_legal(wr_data[6:4])) |=> (rd_data[6:4] == 3'b000));

  // R2: written fields appear at their bit positions
  p_layout_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[7] == $past(wr_data[7]) && rd_data[2:0] == $past(wr_data[2:0])));
endmodule

// File: rtl/arb_prio_order.sv
module arb_prio_order
  import arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic [2:0]       fix_code,
  input  logic [N_MST-1:0] rot_en,
  input  logic [N_MST-1:0] req_act,
  input  logic             issue,
  input  mst_idx_t         issue_idx,
  output logic             win_valid,
  output mst_idx_t         win_idx
);
  order_t order_q;
  order_t order_rot;
  logic   rot_hit;
  int     pos;

  // winner: first requesting master from the top of the order
  always_comb begin
    win_valid = 1'b0;
    win_idx   = HOST_ID;
    for (int p = N_MST - 1; p >= 0; p--) begin
      if (req_act[order_q[p]]) begin
        win_valid = 1'b1;
        win_idx   = order_q[p];
      end
    end
  end

  // served master drops to the bottom, those below it move up
  always_comb begin
    pos = N_MST - 1;
    for (int p = N_MST - 1; p >= 0; p--) begin
      if (order_q[p] == issue_idx) pos = p;
    end
    order_rot = order_q;
    for (int p = 0; p < N_MST - 1; p++) begin
      if (p >= pos) order_rot[p] = order_q[p+1];
    end
    order_rot[N_MST-1] = issue_idx;
  end

  assign rot_hit = issue && (issue_idx != HOST_ID) && rot_en[issue_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       order_q <= fixed_order(3'b000);
    else if (reload)  order_q <= fixed_order(fix_code);
    else if (rot_hit) order_q <= order_rot;
  end

  // R4: with no rotation enabled the order never moves
  p_fixed_static_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && rot_en == '0) |=> $stable(order_q));

  // R5: a rotating master lands at the lowest position after its grant
  p_rot_bottom_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && issue && issue_idx != HOST_ID && rot_en[issue_idx])
      |=> (order_q[N_MST-1] == $past(issue_idx)));

  // R12: the order changes only on a grant or a reload
  p_order_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && !issue) |=> $stable(order_q));
endmodule

// File: rtl/arb_tenure_fsm.sv
module arb_tenure_fsm
  import arb_pkg::*;
#(
  parameter int GAP_CYCLES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_idle,
  input  logic             pp_en,
  input  logic             win_valid,
  input  mst_idx_t         win_idx,
  output logic [N_MST-1:0] pci_gnt,
  output logic             host_gnt,
  output logic             issue,
  output mst_idx_t         issue_idx
);
  localparam int CNT_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] GAP_LOAD = CNT_W'(GAP_CYCLES - 1);

  phase_e          phase_q;
  mst_idx_t        owner_q;
  mst_idx_t        next_q;
  logic [CNT_W-1:0] gap_cnt_q;
  logic            host_due_q;
  mst_idx_t        pick;
  logic            stay;
  logic [N_MST:0]  grant_vec;

  always_comb begin
    pick = HOST_ID;
    if (pp_en && host_due_q) pick = HOST_ID;
    else if (win_valid)      pick = win_idx;
  end

  assign stay      = (pick == HOST_ID) && (owner_q == HOST_ID);
  assign issue     = (phase_q == PH_GAP) && (gap_cnt_q == '0);
  assign issue_idx = next_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_TENURE;
      owner_q    <= HOST_ID;
      next_q     <= HOST_ID;
      gap_cnt_q  <= '0;
      host_due_q <= 1'b0;
    end else begin
      case (phase_q)
        PH_TENURE: begin
          if (bus_idle && !stay) begin
            phase_q   <= PH_GAP;
            next_q    <= pick;
            gap_cnt_q <= GAP_LOAD;
          end
        end
        default: begin
          if (issue) begin
            phase_q    <= PH_TENURE;
            owner_q    <= next_q;
            host_due_q <= (next_q != HOST_ID);
          end else begin
            gap_cnt_q <= gap_cnt_q - 1'b1;
          end
        end
      endcase
    end
  end

  for (genvar i = 0; i < N_MST; i++) begin : g_gnt
    assign pci_gnt[i] = (phase_q == PH_TENURE) && (owner_q == mst_idx_t'(i));
  end
  assign host_gnt  = (phase_q == PH_TENURE) && (owner_q == HOST_ID);
  assign grant_vec = {host_gnt, pci_gnt};

  // R8: never more than one grant
  p_one_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant_vec) <= 1);

  // R9: a busy bus keeps its owner
  p_hold_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vec != '0 && !bus_idle) |=> $stable(grant_vec));

  // R10: a new grant follows a cycle with no grant
  p_gap_before_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vec != '0 && grant_vec != $past(grant_vec)) |-> ($past(grant_vec) == '0));

  // R11: a parked host with nobody eligible keeps the bus
  p_park_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (host_gnt && !win_valid) |=> host_gnt);

  // R7: in alternation mode an external tenure hands over to the host
  p_pp_host_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pp_en && bus_idle && pci_gnt != '0) |=> (next_q == HOST_ID));
endmodule

// File: rtl/tri_master_bus_arbiter.sv
module tri_master_bus_arbiter
  import arb_pkg::*;
#(
  parameter int GAP_CYCLES = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr_en,
  input  logic [7:0] cfg_wr_data,
  output logic [7:0] cfg_rd_data,
  input  logic [2:0] req_n,
  input  logic       bus_idle,
  output logic [2:0] gnt_n,
  output logic       host_gnt
);
  cfg_t             cfg;
  logic             reload;
  logic             win_valid;
  mst_idx_t         win_idx;
  logic             issue;
  mst_idx_t         issue_idx;
  logic [N_MST-1:0] pci_gnt;

  arb_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .rd_data (cfg_rd_data),
    .cfg     (cfg),
    .reload  (reload)
  );

  arb_prio_order u_order (
    .clk       (clk),
    .rst_n     (rst_n),
    .reload    (reload),
    .fix_code  (cfg.fix_code),
    .rot_en    (cfg.rot_en),
    .req_act   (~req_n),
    .issue     (issue),
    .issue_idx (issue_idx),
    .win_valid (win_valid),
    .win_idx   (win_idx)
  );

  arb_tenure_fsm #(.GAP_CYCLES(GAP_CYCLES)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_idle  (bus_idle),
    .pp_en     (cfg.pp_en),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .pci_gnt   (pci_gnt),
    .host_gnt  (host_gnt),
    .issue     (issue),
    .issue_idx (issue_idx)
  );

  assign gnt_n = ~pci_gnt;
endmodule

// File: tb/tb_tri_master_bus_arbiter.sv
`timescale 1ns/1ps
module tb_tri_master_bus_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic [7:0] cfg_wr_data = 8'h00;
  logic [7:0] cfg_rd_data;
  logic [2:0] req_n = 3'b111;
  logic       bus_idle = 1'b0;
  logic [2:0] gnt_n;
  logic       host_gnt;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tri_master_bus_arbiter dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .req_n(req_n), .bus_idle(bus_idle),
    .gnt_n(gnt_n), .host_gnt(host_gnt)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // 0..2 external master, 3 host, 4 nobody, 5 several
  function automatic int owner();
    int n = 0;
    int w = 4;
    if (host_gnt) begin n++; w = 3; end
    for (int i = 0; i < 3; i++) if (!gnt_n[i]) begin n++; w = i; end
    return (n > 1) ? 5 : w;
  endfunction

  // expected list from R4
  function automatic int exp_order(input int code, input int p);
    int t[3];
    case (code)
      1: t = '{1, 0, 2};
      2: t = '{0, 2, 1};
      4: t = '{1, 2, 0};
      6: t = '{2, 1, 0};
      7: t = '{2, 0, 1};
      default: t = '{0, 1, 2};
    endcase
    return t[p];
  endfunction

  task automatic write_cfg(input logic [7:0] v);
    cfg_wr_en = 1'b1;
    cfg_wr_data = v;
    step();
    cfg_wr_en = 1'b0;
    step();
  endtask

  // end the current tenure, check the gap, return the next owner
  task automatic arbitrate(output int w);
    bus_idle = 1'b1;
    step();
    check(owner() == 4, "R10", "no grant during handover", owner(), 4);
    bus_idle = 1'b0;
    step();
    w = owner();
    check(w != 5, "R8", "single grant", w, 0);
  endtask

  task automatic t_reset();
    check(cfg_rd_data == 8'h00, "R1", "register after reset", cfg_rd_data, 0);
    check(host_gnt == 1'b1, "R1", "host grant after reset", host_gnt, 1);
    check(gnt_n == 3'b111, "R1", "external grants after reset", gnt_n, 7);
  endtask

  task automatic t_register();
    write_cfg(8'hFF);
    check(cfg_rd_data == 8'hF7, "R2", "bit 3 reads 0", cfg_rd_data, 8'hF7);
    write_cfg(8'h25);
    check(cfg_rd_data == 8'h25, "R2", "field layout", cfg_rd_data, 8'h25);
    write_cfg(8'hB2);
    check(cfg_rd_data == 8'h82, "R3", "code 011 folds", cfg_rd_data, 8'h82);
    write_cfg(8'h51);
    check(cfg_rd_data == 8'h01, "R3", "code 101 folds", cfg_rd_data, 8'h01);
    write_cfg(8'h00);
  endtask

  task automatic t_fixed();
    int codes[6] = '{0, 1, 2, 4, 6, 7};
    int w;
    foreach (codes[k]) begin
      write_cfg(8'(codes[k] << 4));
      req_n = 3'b000;
      for (int p = 0; p < 3; p++) begin
        arbitrate(w);
        check(w == exp_order(codes[k], p), "R4", $sformatf("code %0d pos %0d", codes[k], p),
              w, exp_order(codes[k], p));
        if (w < 3) req_n[w] = 1'b1;
      end
      arbitrate(w);
      check(w == 3, "R11", "back to host when idle", w, 3);
    end
  endtask

  task automatic t_rotate();
    int seq[5] = '{0, 1, 2, 0, 1};
    int w;
    write_cfg(8'h07);
    req_n = 3'b000;
    foreach (seq[k]) begin
      arbitrate(w);
      check(w == seq[k], "R5", $sformatf("round robin step %0d", k), w, seq[k]);
    end
    req_n = 3'b111;
    arbitrate(w);
    check(w == 3, "R11", "host after round robin", w, 3);
  endtask

  task automatic t_hybrid();
    int seq[3] = '{0, 1, 1};
    int w;
    write_cfg(8'h01);
    req_n = 3'b000;
    foreach (seq[k]) begin
      arbitrate(w);
      check(w == seq[k], "R6", $sformatf("hybrid step %0d", k), w, seq[k]);
    end
    req_n = 3'b111;
    arbitrate(w);
  endtask

  task automatic t_reload();
    int w;
    write_cfg(8'h07);
    req_n = 3'b000;
    arbitrate(w);
    check(w == 0, "R12", "first after write", w, 0);
    req_n = 3'b111;
    arbitrate(w);
    write_cfg(8'h07);
    req_n = 3'b000;
    arbitrate(w);
    check(w == 0, "R12", "order reloaded by write", w, 0);
    req_n = 3'b111;
    arbitrate(w);
  endtask

  task automatic t_pingpong();
    int seq[4] = '{0, 3, 0, 3};
    int w;
    write_cfg(8'h80);
    req_n = 3'b000;
    foreach (seq[k]) begin
      arbitrate(w);
      check(w == seq[k], "R7", $sformatf("alternation step %0d", k), w, seq[k]);
    end
    req_n = 3'b111;
    write_cfg(8'h00);
  endtask

  task automatic t_hold();
    int w;
    req_n = 3'b011;
    arbitrate(w);
    check(w == 2, "R9", "master 2 granted", w, 2);
    req_n = 3'b110;
    for (int k = 0; k < 5; k++) begin
      step();
      check(gnt_n == 3'b011 && !host_gnt, "R9", "grant held while busy", gnt_n, 3);
    end
    req_n = 3'b111;
    arbitrate(w);
    check(w == 3, "R11", "host after release", w, 3);
  endtask

  task automatic t_park();
    bus_idle = 1'b1;
    for (int k = 0; k < 5; k++) begin
      step();
      check(host_gnt == 1'b1 && gnt_n == 3'b111, "R11", "parked host keeps grant",
            host_gnt, 1);
    end
    bus_idle = 1'b0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_register();
    t_fixed();
    t_rotate();
    t_hybrid();
    t_reload();
    t_pingpong();
    t_hold();
    t_park();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule